// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register bank of one general-purpose I/O port with 18 pins. It sits on a simple bus that completes every access in the cycle it is presented, and that carries byte, halfword and word transfers. The bank holds three pieces of state: the output latch, the direction register and the mask register. It offers several ways of looking at the pins and the latch. Each pin has its own byte-wide alias and its own word-wide alias. The whole port can be seen directly or through the mask. Set, clear and toggle write ports also act on the same latch.

The bank takes pin levels that are already synchronised and a per-pin analog flag. It drives the output vector and the output-enable vector toward the pads. Read data is combinational from the address and the current state. A write takes effect at the rising clock edge that ends the access.

Byte lane k of the data bus is bits 8k+7:8k. For byte accesses the lane is chosen by address bits 1:0, and for halfword accesses by address bit 1. Word accesses use all four lanes. `bus_size` encodes 0 as byte, 1 as halfword, and 2 or 3 as word.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the output latch, the direction register and the mask register are all 0, so `gpio_out` and `gpio_oe` are 0.
- R2: A read at a byte-alias offset n (0x000 to 0x013) returns pin n's level in bit 0 of its lane and 0 in bits 7:1. Each enabled lane maps to pin (address & ~3) + lane, and pins that do not exist read 0.
- R3: A write at a byte-alias offset loads bit 0 of each enabled lane into that pin's output latch. Bits 7:1 have no effect.
- R4: A read of pin n's word alias (0x1000 + 4n) returns all ones in the enabled lanes when the pin is high, and 0 when it is low. A write sets the latch bit when the enabled lanes of the write data hold any 1, and clears it when they are all zero.
- R5: A pin whose analog flag is 1 reads as 0 through its byte alias, its word alias, the port view (0x2100) and the masked port view (0x2180).
- R6: The port view at 0x2100 reads the pin levels whatever the mask. A write there loads the latch bits of the enabled lanes.
- R7: The masked port view at 0x2180 reads 0 for pins whose mask bit is 1. A write there changes only the latch bits whose mask bit is 0.
- R8: A write to 0x2200 sets the latch bits written as 1 and leaves the rest unchanged. A read of 0x2200 returns the latch.
- R9: A write to 0x2280 clears, and a write to 0x2300 inverts, the latch bits written as 1. Both offsets read as 0.
- R10: `gpio_oe` equals the direction register at 0x2000, where 1 means output. The mask register sits at 0x2080.
- R11: A byte or halfword write to a port-wide register changes only the bits of its enabled lanes.
- R12: Bits 31:18 of every port-wide register read as 0. Unmapped offsets and any clock without a read request return 0 on `bus_rdata`.
- R13: A clock edge with `bus_sel` low leaves the latch, the direction register and the mask register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 14 | Byte offset inside the bank |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_wdata | input | 32 | Write data, on lanes selected by the address |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| pin_in | input | 18 | Synchronised pin levels |
| pin_analog | input | 18 | 1 marks a pin in analog mode |
| gpio_out | output | 18 | Output latch |
| gpio_oe | output | 18 | Output enables, from the direction register |

## Verification
Directed accesses come first. They address each view with a pin pattern whose neighbouring bits differ, so a lane that is swapped or shifted shows up. Analog flags are placed on high pins, so masking by the analog flag can be told apart from masking by the direction or mask register. The word-alias write is tried with a nonzero value in only the top lane, which separates an any-bit-set test from a look at bit 0. Random traffic follows: a fixed seed mixes all views, all access sizes, unmapped offsets and changing pin and analog patterns, and every write is checked through the output ports.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

  localparam int ADDR_W = 14;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [3:0] {
    RG_NONE, RG_BYTE, RG_WORD, RG_DIR, RG_MASK,
    RG_PIN,  RG_MPIN, RG_SET,  RG_CLR, RG_TGL
  } region_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  function automatic logic [LANES-1:0] lane_en(input logic [1:0] lo, input logic [1:0] sz);
    logic [LANES-1:0] r;
    if (sz == SZ_BYTE)      r = 4'b0001 << lo;
    else if (sz == SZ_HALF) r = lo[1] ? 4'b1100 : 4'b0011;
    else                    r = 4'b1111;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < LANES; k++) r[8*k +: 8] = {8{be[k]}};
    return r;
  endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
`timescale 1ns/1ps
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output region_e           region,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lmask,
  output logic [2:0]        byte_grp,
  output logic [4:0]        alias_pin
);

  localparam logic [9:0] LAST_GRP = 10'((NPINS - 1) / 4);

  logic [1:0] page;
  logic       byte_hit;
  logic       word_hit;
  logic       port_hit;

  assign page      = addr[13:12];
  assign byte_grp  = addr[4:2];
  assign alias_pin = addr[6:2];
  assign be        = lane_en(addr[1:0], size);
  assign lmask     = lane_bits(be);

  assign byte_hit = (page == 2'd0) && (addr[11:2] <= LAST_GRP);
  assign word_hit = (page == 2'd1) && (addr[11:7] == 5'd0) &&
                    (32'(addr[6:2]) < NPINS);
  assign port_hit = (page == 2'd2) && (addr[11:10] == 2'd0) &&
                    (addr[6:2] == 5'd0);

  always_comb begin
    region = RG_NONE;
    if (byte_hit) begin
      region = RG_BYTE;
    end else if (word_hit) begin
      region = RG_WORD;
    end else if (port_hit) begin
      case (addr[9:7])
        3'd0:    region = RG_DIR;
        3'd1:    region = RG_MASK;
        3'd2:    region = RG_PIN;
        3'd3:    region = RG_MPIN;
        3'd4:    region = RG_SET;
        3'd5:    region = RG_CLR;
        3'd6:    region = RG_TGL;
        default: region = RG_NONE;
      endcase
    end
  end

  initial begin
    if (NPINS < 1 || NPINS > 32) $error("NPINS must be in 1..32");
  end

endmodule

// File: rtl/gpio_bank_rdmux.sv
`timescale 1ns/1ps
module gpio_bank_rdmux
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 18
) (
  input  region_e           region,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] lmask,
  input  logic [2:0]        byte_grp,
  input  logic [4:0]        alias_pin,
  input  logic [NPINS-1:0]  level,
  input  logic [NPINS-1:0]  out_q,
  input  logic [NPINS-1:0]  dir_q,
  input  logic [NPINS-1:0]  mask_q,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] lvl32;
  logic [DATA_W-1:0] byte_rd;
  logic [DATA_W-1:0] word_rd;
  logic [DATA_W-1:0] port_rd;

  assign lvl32 = DATA_W'(level);

  always_comb begin
    byte_rd = '0;
    for (int k = 0; k < LANES; k++) begin
      if (be[k]) byte_rd[8*k] = lvl32[{byte_grp, 2'(k)}];
    end
  end

  assign word_rd = lvl32[alias_pin] ? lmask : '0;

  always_comb begin
    case (region)
      RG_DIR:  port_rd = DATA_W'(dir_q);
      RG_MASK: port_rd = DATA_W'(mask_q);
      RG_PIN:  port_rd = DATA_W'(level);
      RG_MPIN: port_rd = DATA_W'(level & ~mask_q);
      RG_SET:  port_rd = DATA_W'(out_q);
      default: port_rd = '0;
    endcase
  end

  always_comb begin
    case (region)
      RG_BYTE: rdata = byte_rd;
      RG_WORD: rdata = word_rd;
      RG_NONE: rdata = '0;
      default: rdata = port_rd & lmask;
    endcase
  end

endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  region_e           region,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] lmask,
  input  logic [2:0]        byte_grp,
  input  logic [4:0]        alias_pin,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  mask_q
);

  logic [NPINS-1:0] lm;
  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] out_n;
  logic [NPINS-1:0] dir_n;
  logic [NPINS-1:0] mask_n;
  logic             out_en;
  logic             dir_en;
  logic             mask_en;
  logic             any_set;

  assign lm      = lmask[NPINS-1:0];
  assign wd      = wdata[NPINS-1:0];
  assign any_set = |(wdata & lmask);

  assign out_en  = wr_en && (region inside {RG_BYTE, RG_WORD, RG_PIN, RG_MPIN,
                                            RG_SET, RG_CLR, RG_TGL});
  assign dir_en  = wr_en && (region == RG_DIR);
  assign mask_en = wr_en && (region == RG_MASK);

  always_comb begin
    out_n = out_q;
    case (region)
      RG_BYTE: begin
        for (int p = 0; p < NPINS; p++) begin
          if (byte_grp == 3'(p / 4) && be[p % 4]) out_n[p] = wdata[8 * (p % 4)];
        end
      end
      RG_WORD: begin
        for (int p = 0; p < NPINS; p++) begin
          if (alias_pin == 5'(p)) out_n[p] = any_set;
        end
      end
      RG_PIN:  out_n = (out_q & ~lm) | (wd & lm);
      RG_MPIN: out_n = (out_q & (mask_q | ~lm)) | (wd & lm & ~mask_q);
      RG_SET:  out_n = out_q | (wd & lm);
      RG_CLR:  out_n = out_q & ~(wd & lm);
      RG_TGL:  out_n = out_q ^ (wd & lm);
      default: out_n = out_q;
    endcase
  end

  assign dir_n  = (dir_q  & ~lm) | (wd & lm);
  assign mask_n = (mask_q & ~lm) | (wd & lm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else begin
      if (out_en)  out_q  <= out_n;
      if (dir_en)  dir_q  <= dir_n;
      if (mask_en) mask_q <= mask_n;
    end
  end

  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region == RG_SET) |=> ((~out_q & $past(out_q)) == '0)) else $error("set cleared a bit"); // R8
  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region == RG_CLR) |=> ((out_q & ~$past(out_q)) == '0)) else $error("clear set a bit"); // R9
  AST_MPIN_HIDDEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region == RG_MPIN) |=> ((out_q & $past(mask_q)) == ($past(out_q) & $past(mask_q)))) else $error("hidden bit changed"); // R7
  AST_DIR_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && region == RG_DIR && be == 4'hF) |=> (dir_q == $past(wd))) else $error("direction not loaded"); // R10

endmodule

// File: rtl/gpio_port_bank.sv
`timescale 1ns/1ps
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [13:0]       bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  pin_analog,
  output logic [NPINS-1:0]  gpio_out,
  output logic [NPINS-1:0]  gpio_oe
);

  region_e           region;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] lmask;
  logic [2:0]        byte_grp;
  logic [4:0]        alias_pin;
  logic [NPINS-1:0]  level;
  logic [NPINS-1:0]  out_q;
  logic [NPINS-1:0]  dir_q;
  logic [NPINS-1:0]  mask_q;
  logic [DATA_W-1:0] mux_rd;
  logic              rd_req;
  logic              wr_en;

  assign level  = pin_in & ~pin_analog;
  assign rd_req = bus_sel && !bus_wr;
  assign wr_en  = bus_sel && bus_wr;

  gpio_bank_decode #(.NPINS(NPINS)) u_decode (
    .addr      (bus_addr),
    .size      (bus_size),
    .region    (region),
    .be        (be),
    .lmask     (lmask),
    .byte_grp  (byte_grp),
    .alias_pin (alias_pin)
  );

  gpio_bank_rdmux #(.NPINS(NPINS)) u_rdmux (
    .region    (region),
    .be        (be),
    .lmask     (lmask),
    .byte_grp  (byte_grp),
    .alias_pin (alias_pin),
    .level     (level),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .rdata     (mux_rd)
  );

  gpio_bank_regs #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .region    (region),
    .be        (be),
    .lmask     (lmask),
    .byte_grp  (byte_grp),
    .alias_pin (alias_pin),
    .wdata     (bus_wdata),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .mask_q    (mask_q)
  );

  assign bus_rdata = rd_req ? mux_rd : '0;
  assign gpio_out  = out_q;
  assign gpio_oe   = dir_q;

  AST_PORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && region inside {RG_DIR, RG_MASK, RG_PIN, RG_MPIN, RG_SET, RG_CLR, RG_TGL})
    |-> (bus_rdata[31:NPINS] == '0)) else $error("upper bits set"); // R12
  AST_WORD_ALIAS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && region == RG_WORD) |-> (bus_rdata == '0 || bus_rdata == lmask)) else $error("word alias not uniform"); // R4
  AST_BYTE_ALIAS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && region == RG_BYTE) |-> ((bus_rdata & 32'hFEFE_FEFE) == '0)) else $error("byte alias high bits"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> ($stable(gpio_out) && $stable(gpio_oe))) else $error("state moved while idle"); // R13

endmodule

// File: tb/gpio_port_bank_tb.sv
`timescale 1ns/1ps
module gpio_port_bank_tb;

  localparam int NP = 18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [13:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_analog;
  logic [NP-1:0] gpio_out;
  logic [NP-1:0] gpio_oe;

  logic [NP-1:0] m_out, m_dir, m_mask;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_analog(pin_analog),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] t_be(input logic [13:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001 << a[1:0];
      2'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] t_lm(input logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = be[k] ? 8'hFF : 8'h00;
    return r;
  endfunction

  function automatic int t_kind(input logic [13:0] a);
    if (a < 14'h0014) return 1;
    if (a >= 14'h1000 && a < 14'h1048) return 2;
    if (a[13:12] == 2'd2 && a[11:10] == 2'd0 && a[6:2] == 5'd0 && a[9:7] != 3'd7)
      return 3 + int'(a[9:7]);
    return 0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [13:0] a, input logic [1:0] sz);
    logic [3:0]  be = t_be(a, sz);
    logic [31:0] lm = t_lm(be);
    logic [31:0] lv = 32'(pin_in & ~pin_analog);
    logic [31:0] r = '0;
    int kd = t_kind(a);
    if (kd == 1) begin
      for (int k = 0; k < 4; k++) begin
        if (be[k]) r[8*k] = lv[int'(a[4:2]) * 4 + k];
      end
    end else if (kd == 2) begin
      r = lv[a[6:2]] ? lm : 32'h0;
    end else if (kd == 3) r = 32'(m_dir) & lm;
    else if (kd == 4) r = 32'(m_mask) & lm;
    else if (kd == 5) r = lv & lm;
    else if (kd == 6) r = lv & ~32'(m_mask) & lm;
    else if (kd == 7) r = 32'(m_out) & lm;
    return r;
  endfunction

  task automatic model_write(input logic [13:0] a, input logic [1:0] sz, input logic [31:0] d);
    logic [3:0]    be = t_be(a, sz);
    logic [31:0]   lm = t_lm(be);
    logic [NP-1:0] w = d[NP-1:0] & lm[NP-1:0];
    logic [NP-1:0] l = lm[NP-1:0];
    int kd = t_kind(a);
    int p;
    if (kd == 1) begin
      for (int k = 0; k < 4; k++) begin
        p = int'(a[4:2]) * 4 + k;
        if (be[k] && p < NP) m_out[p] = d[8*k];
      end
    end else if (kd == 2) m_out[a[6:2]] = ((d & lm) != 0);
    else if (kd == 3) m_dir  = (m_dir & ~l) | w;
    else if (kd == 4) m_mask = (m_mask & ~l) | w;
    else if (kd == 5) m_out  = (m_out & ~l) | w;
    else if (kd == 6) m_out  = (m_out & (m_mask | ~l)) | (w & ~m_mask);
    else if (kd == 7) m_out  = m_out | w;
    else if (kd == 8) m_out  = m_out & ~w;
    else if (kd == 9) m_out  = m_out ^ w;
  endtask

  task automatic do_write(input logic [13:0] a, input logic [1:0] sz, input logic [31:0] d, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk);
    model_write(a, sz, d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    #1;
    chk(gpio_out == m_out, {tag, " out"}, 32'(gpio_out), 32'(m_out));
    chk(gpio_oe == m_dir, {tag, " oe"}, 32'(gpio_oe), 32'(m_dir));
    @(negedge clk);
  endtask

  task automatic do_read(input logic [13:0] a, input logic [1:0] sz, input string tag);
    logic [31:0] e;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz; bus_wdata = $urandom;
    #1;
    e = exp_read(a, sz);
    chk(bus_rdata == e, tag, bus_rdata, e);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0C0FFEE5));
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_size = '0;
    bus_wdata = '0; pin_in = '0; pin_analog = '0;
    m_out = '0; m_dir = '0; m_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(gpio_out == '0, "R1 out reset", 32'(gpio_out), 0);
    chk(gpio_oe == '0, "R1 oe reset", 32'(gpio_oe), 0);
    chk(bus_rdata == '0, "R12 idle rdata", bus_rdata, 0);
    @(negedge clk);
    do_read(14'h2000, 2'd2, "R1 dir reset");
    do_read(14'h2080, 2'd2, "R1 mask reset");

    pin_in = 18'h2A5A5;
    do_read(14'h0000, 2'd0, "R2 byte pin0");
    do_read(14'h0001, 2'd0, "R2 byte pin1");
    do_read(14'h0004, 2'd2, "R2 word over pins 4-7");
    do_read(14'h0010, 2'd1, "R2 half pins 16-17");
    do_read(14'h0012, 2'd1, "R2 half missing pins");

    pin_in = 18'h3FFFF; pin_analog = 18'h20008;
    do_read(14'h0003, 2'd0, "R5 byte analog");
    do_read(14'h100C, 2'd2, "R5 word alias analog");
    do_read(14'h2100, 2'd2, "R5 port analog");
    do_read(14'h2180, 2'd2, "R5 mpin analog");
    pin_analog = '0;

    do_write(14'h0005, 2'd0, 32'h0000FE00, "R3 byte high bits ignored");
    do_write(14'h0005, 2'd0, 32'h00000100, "R3 byte load one");
    do_write(14'h0000, 2'd2, 32'h01FE01FE, "R3 word four pins");
    do_write(14'h1044, 2'd2, 32'h80000000, "R4 alias top lane only");
    do_write(14'h1044, 2'd2, 32'h00000000, "R4 alias zero clears");
    do_write(14'h1009, 2'd0, 32'h00000400, "R4 alias byte lane");
    pin_in = 18'h00004;
    do_read(14'h1008, 2'd2, "R4 alias high read");
    do_read(14'h100C, 2'd1, "R4 alias low read");

    do_write(14'h2080, 2'd2, 32'h0000000F, "R10 mask load");
    do_write(14'h2100, 2'd2, 32'hFFFFFFFF, "R6 port write");
    do_read(14'h2100, 2'd2, "R6 port ignores mask");
    do_write(14'h2180, 2'd2, 32'h00000000, "R7 mpin hidden kept");
    pin_in = 18'h3FFFF;
    do_read(14'h2180, 2'd2, "R7 mpin read");
    do_write(14'h2200, 2'd2, 32'h00030010, "R8 set");
    do_read(14'h2200, 2'd2, "R8 set reads latch");
    do_write(14'h2280, 2'd2, 32'h00010001, "R9 clear");
    do_write(14'h2300, 2'd2, 32'h0000FF00, "R9 toggle");
    do_read(14'h2280, 2'd2, "R9 clear reads zero");
    do_read(14'h2300, 2'd2, "R9 toggle reads zero");
    do_write(14'h2000, 2'd2, 32'h00000003, "R10 dir to oe");
    do_write(14'h2001, 2'd0, 32'h0000AB00, "R11 dir byte lane");
    do_write(14'h2202, 2'd1, 32'hFFFF0000, "R11 set half lane");
    do_read(14'h2000, 2'd2, "R11 dir readback");
    do_read(14'h3000, 2'd2, "R12 unmapped");
    do_read(14'h2380, 2'd2, "R12 unmapped port slot");
    do_read(14'h1048, 2'd2, "R12 past last alias");
    do_read(14'h2200, 2'd2, "R12 upper bits zero");

    bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 14'h2300; bus_size = 2'd2; bus_wdata = 32'hFFFFFFFF;
    repeat (2) @(negedge clk);
    #1;
    chk(gpio_out == m_out, "R13 idle out", 32'(gpio_out), 32'(m_out));
    chk(gpio_oe == m_dir, "R13 idle oe", 32'(gpio_oe), 32'(m_dir));
    bus_wr = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 800; i++) begin
      logic [13:0] a;
      logic [1:0]  sz;
      int kd;
      if (($urandom % 4) == 0) begin
        pin_in = 18'($urandom);
        pin_analog = 18'($urandom) & 18'($urandom);
      end
      kd = $urandom % 4;
      sz = 2'($urandom % 3);
      case (kd)
        0:       a = 14'($urandom % 20);
        1:       a = 14'h1000 + 14'(($urandom % 18) * 4) + 14'($urandom % 4);
        2:       a = 14'h2000 + 14'(($urandom % 8) * 128) + 14'($urandom % 4);
        default: a = 14'($urandom);
      endcase
      if (sz == 2'd1) a[0] = 1'b0;
      if (sz == 2'd2) a[1:0] = 2'b00;
      if ($urandom % 2) do_write(a, sz, $urandom, "R3 R4 R6 R7 R8 R9 R11 random write");
      else              do_read(a, sz, "R2 R4 R5 R6 R7 R12 random read");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule